// File: doc/BRIEF.md
# Almost-Regular Permutation Address Generator

This block drives the address side of the shuffle that sits between the two constituent soft-in/soft-out decoders of a parallel concatenated convolutional decoder. After a start request it walks a frame index from zero up to the frame length minus one, producing one permuted address per clock. The permutation is the almost-regular kind: a fixed odd stride times the index, plus an offset taken from a short vector that repeats with the index, all reduced modulo the frame length. Which stride and vector apply depends on the frame length, which is chosen at start from three power-of-two sizes.

The stride term is carried in an accumulator, and the modulo is a truncation to the frame's bit width. No multiplier or divider sits in the datapath. A second mode emits the reverse mapping: at step j the block gives the index whose forward address is j. Each address comes with a valid flag and a last flag. The frame length and mode are captured at start and held for the whole frame. A start request that arrives mid-frame, or that names the unused size code, has no effect.

Top module: `arp_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after reset, `valid_o` and `last_o` are 0.
- R2: A start accepted while idle makes `valid_o` high from the next cycle on, for exactly K consecutive cycles, with the step index going 0, 1, ..., K-1.
- R3: `size_sel` codes 0, 1 and 2 select K=128 (stride 49, period 4, offsets 3,113,111,93), K=256 (stride 79, period 16, offsets 8,16,39,170,74,87,122,26,168,165,24,88,245,216,232,192) and K=512 (stride 61, period 16, offsets 8,50,107,192,258,289,454,360,376,7,316,494,173,434,292,398). In forward mode (`inverse`=0), step i emits (stride*i + offset[i mod period]) mod K.
- R4: `last_o` is high exactly on step K-1, and `valid_o` is low in the cycle after it.
- R5: A start request while a frame is running is ignored. Changes to `size_sel` and `inverse` during a frame have no effect on that frame.
- R6: In reverse mode (`inverse`=1), step j emits the index i whose forward address is j.
- R7: In both modes the K addresses of a frame are all distinct.
- R8: A start with `size_sel`=3 is ignored: no frame begins.
- R9: Every emitted address is below K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start request |
| size_sel | input | 2 | Frame size code (0:128, 1:256, 2:512, 3:unused) |
| inverse | input | 1 | 1 selects the reverse mapping |
| addr_o | output | 9 | Permuted address of the current step |
| valid_o | output | 1 | Address is valid this cycle |
| last_o | output | 1 | Final step of the frame |

## Verification
The bench sweeps every step of all three frame sizes in both modes. It compares forward addresses against the product formula and checks reverse outputs by mapping them forward again. Per-frame occupancy tracking catches a repeated address, which an accumulator that wraps at the wrong width or a wrong reverse offset would produce. It aims a start pulse carrying a different size and mode into the middle of a frame: a design that re-launches or reloads its configuration would cut the frame short or switch tables. The unused size code is checked for silence, and the last flag is checked on every step, so an off-by-one end count shows up as a misplaced last or a frame that is one step too long.

// File: rtl/arp_pkg.sv
package arp_pkg;
  localparam int unsigned LOG_K_MAX = 9;
  localparam int unsigned PER_MAX   = 16;

  typedef logic [LOG_K_MAX-1:0] addr_t;
  typedef enum logic [1:0] {FR_128 = 2'd0, FR_256 = 2'd1, FR_512 = 2'd2, FR_RSV = 2'd3} frame_sel_e;

  function automatic int unsigned frame_len(frame_sel_e s);
    case (s)
      FR_128:  return 128;
      FR_256:  return 256;
      FR_512:  return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned stride(frame_sel_e s);
    case (s)
      FR_128:  return 49;
      FR_256:  return 79;
      FR_512:  return 61;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned period(frame_sel_e s);
    return (s == FR_128) ? 4 : 16;
  endfunction

  function automatic int unsigned offset(frame_sel_e s, int unsigned r);
    int unsigned v;
    v = 0;
    if (s == FR_128) begin
      case (r & 3)
        0: v = 3;   1: v = 113; 2: v = 111; default: v = 93;
      endcase
    end else if (s == FR_256) begin
      case (r & 15)
        0: v = 8;    1: v = 16;   2: v = 39;   3: v = 170;
        4: v = 74;   5: v = 87;   6: v = 122;  7: v = 26;
        8: v = 168;  9: v = 165;  10: v = 24;  11: v = 88;
        12: v = 245; 13: v = 216; 14: v = 232; default: v = 192;
      endcase
    end else if (s == FR_512) begin
      case (r & 15)
        0: v = 8;    1: v = 50;   2: v = 107;  3: v = 192;
        4: v = 258;  5: v = 289;  6: v = 454;  7: v = 360;
        8: v = 376;  9: v = 7;    10: v = 316; 11: v = 494;
        12: v = 173; 13: v = 434; 14: v = 292; default: v = 398;
      endcase
    end
    return v;
  endfunction

  // Inverse of the odd stride modulo 2^32 by Newton steps; truncate to K bits later.
  function automatic int unsigned stride_inv(frame_sel_e s);
    int unsigned p;
    int unsigned x;
    p = stride(s);
    x = p;
    for (int n = 0; n < 5; n++) x = x * (32'd2 - p * x);
    return x & (frame_len(s) - 1);
  endfunction

  // Residue class r whose forward addresses fall in residue jr of the period.
  function automatic int unsigned inv_residue(frame_sel_e s, int unsigned jr);
    int unsigned res;
    int unsigned pm;
    res = 0;
    pm  = period(s) - 1;
    for (int unsigned r = 0; r < PER_MAX; r++)
      if (r <= pm && (((stride(s) * r + offset(s, r)) & pm) == (jr & pm))) res = r;
    return res;
  endfunction

  // Constant added in reverse mode: minus stride_inv * offset, modulo K.
  function automatic int unsigned inv_offset(frame_sel_e s, int unsigned r);
    int unsigned m;
    m = frame_len(s) - 1;
    return (frame_len(s) - ((stride_inv(s) * offset(s, r)) & m)) & m;
  endfunction

  // Direct product form of the forward map, for checking.
  function automatic int unsigned fwd_addr(frame_sel_e s, int unsigned i);
    return (stride(s) * i + offset(s, i & (period(s) - 1))) & (frame_len(s) - 1);
  endfunction
endpackage

// File: rtl/arp_ctrl.sv
module arp_ctrl
  import arp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] sel_i,
  input  logic       inv_i,
  output logic       launch_o,
  output logic       busy_o,
  output logic       end_o,
  output addr_t      idx_o,
  output addr_t      mask_o,
  output frame_sel_e sel_q_o,
  output logic       inv_q_o
);
  logic       busy_q;
  addr_t      idx_q;
  frame_sel_e sel_q;
  logic       inv_q;

  assign mask_o   = addr_t'(frame_len(sel_q) - 1);
  assign launch_o = start_i && !busy_q && (frame_sel_e'(sel_i) != FR_RSV);
  assign end_o    = busy_q && (idx_q == mask_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sel_q  <= FR_128;
      inv_q  <= 1'b0;
    end else if (launch_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      sel_q  <= frame_sel_e'(sel_i);
      inv_q  <= inv_i;
    end else if (busy_q) begin
      if (end_o) busy_q <= 1'b0;
      idx_q <= idx_q + addr_t'(1);
    end
  end

  assign busy_o  = busy_q;
  assign idx_o   = idx_q;
  assign sel_q_o = sel_q;
  assign inv_q_o = inv_q;
endmodule

// File: rtl/arp_step_acc.sv
module arp_step_acc
  import arp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear_i,
  input  logic  adv_i,
  input  addr_t step_i,
  input  addr_t mask_i,
  output addr_t acc_o
);
  addr_t acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (adv_i)   acc_q <= (acc_q + step_i) & mask_i;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/arp_offset_sel.sv
module arp_offset_sel
  import arp_pkg::*;
(
  input  frame_sel_e sel_i,
  input  logic       inv_i,
  input  addr_t      idx_i,
  output addr_t      off_o
);
  int unsigned rc;

  always_comb begin
    rc = int'(idx_i) & (period(sel_i) - 1);
    if (inv_i) off_o = addr_t'(inv_offset(sel_i, inv_residue(sel_i, rc)));
    else       off_o = addr_t'(offset(sel_i, rc));
  end
endmodule

// File: rtl/arp_addr_gen.sv
module arp_addr_gen
  import arp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] size_sel,
  input  logic       inverse,
  output logic [8:0] addr_o,
  output logic       valid_o,
  output logic       last_o
);
  logic       launch;
  logic       frame_busy;
  logic       frame_end;
  addr_t      frame_idx;
  addr_t      fr_mask;
  frame_sel_e fr_sel;
  logic       fr_inv;
  addr_t      step;
  addr_t      acc;
  addr_t      off;

  arp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sel_i(size_sel), .inv_i(inverse),
    .launch_o(launch), .busy_o(frame_busy), .end_o(frame_end), .idx_o(frame_idx),
    .mask_o(fr_mask), .sel_q_o(fr_sel), .inv_q_o(fr_inv)
  );

  assign step = fr_inv ? addr_t'(stride_inv(fr_sel)) : addr_t'(stride(fr_sel));

  arp_step_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clear_i(launch), .adv_i(frame_busy),
    .step_i(step), .mask_i(fr_mask), .acc_o(acc)
  );

  arp_offset_sel u_off (
    .sel_i(fr_sel), .inv_i(fr_inv), .idx_i(frame_idx), .off_o(off)
  );

  assign addr_o  = (acc + off) & fr_mask;
  assign valid_o = frame_busy;
  assign last_o  = frame_end;
endmodule

// File: rtl/arp_addr_gen_chk.sv
module arp_addr_gen_chk
  import arp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] size_sel,
  input logic [8:0] addr_o,
  input logic       valid_o,
  input logic       last_o,
  input addr_t      frame_idx,
  input addr_t      fr_mask,
  input frame_sel_e fr_sel,
  input logic       fr_inv
);
  p_last_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  p_gap_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !valid_o);
  p_steps_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> (valid_o && frame_idx == addr_t'($past(frame_idx) + 9'd1)));
  p_cfg_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> ($stable(fr_sel) && $stable(fr_inv)));
  p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (addr_o <= fr_mask));
  p_fwd_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !fr_inv) |-> (addr_o == addr_t'(fwd_addr(fr_sel, int'(frame_idx)))));
  p_rev_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && fr_inv) |-> (addr_t'(fwd_addr(fr_sel, int'(addr_o))) == frame_idx));
  p_rsv_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !valid_o && size_sel == 2'd3) |=> !valid_o);
endmodule

bind arp_addr_gen arp_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
  .addr_o(addr_o), .valid_o(valid_o), .last_o(last_o),
  .frame_idx(frame_idx), .fr_mask(fr_mask), .fr_sel(fr_sel), .fr_inv(fr_inv)
);

// File: tb/sim_arp_addr_gen.sv
module sim_arp_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] size_sel = 2'd0;
  logic       inverse = 1'b0;
  logic [8:0] addr_o;
  logic       valid_o;
  logic       last_o;

  int checks = 0;
  int fails  = 0;
  bit seen [512];

  always #5 clk = ~clk;

  arp_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel), .inverse(inverse),
    .addr_o(addr_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int tb_k(int sel);
    return (sel == 0) ? 128 : (sel == 1) ? 256 : 512;
  endfunction

  function automatic int tb_p(int sel);
    return (sel == 0) ? 49 : (sel == 1) ? 79 : 61;
  endfunction

  function automatic int tb_s(int sel, int r);
    int t128 [4]  = '{3, 113, 111, 93};
    int t256 [16] = '{8, 16, 39, 170, 74, 87, 122, 26, 168, 165, 24, 88, 245, 216, 232, 192};
    int t512 [16] = '{8, 50, 107, 192, 258, 289, 454, 360, 376, 7, 316, 494, 173, 434, 292, 398};
    if (sel == 0) return t128[r % 4];
    if (sel == 1) return t256[r % 16];
    return t512[r % 16];
  endfunction

  function automatic int tb_fwd(int sel, int i);
    int q;
    q = (sel == 0) ? 4 : 16;
    return (tb_p(sel) * i + tb_s(sel, i % q)) % tb_k(sel);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(int sel, bit inv, bit poke);
    int k;
    int distinct;
    k = tb_k(sel);
    for (int a = 0; a < 512; a++) seen[a] = 1'b0;
    distinct = 0;
    @(negedge clk);
    start = 1'b1; size_sel = 2'(sel); inverse = inv;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < k; n++) begin
      chk(valid_o == 1'b1, "R2 valid during frame", int'(valid_o), 1);
      chk(int'(addr_o) < k, "R9 address range", int'(addr_o), k - 1);
      if (!inv) chk(int'(addr_o) == tb_fwd(sel, n), "R3 forward address", int'(addr_o), tb_fwd(sel, n));
      else      chk(tb_fwd(sel, int'(addr_o)) == n, "R6 reverse address maps back", tb_fwd(sel, int'(addr_o)), n);
      chk(last_o == (n == k - 1), "R4 last flag position", int'(last_o), int'(n == k - 1));
      if (!seen[addr_o]) distinct++;
      else chk(1'b0, "R7 repeated address", int'(addr_o), -1);
      seen[addr_o] = 1'b1;
      if (poke && n == 3) begin
        start = 1'b1; size_sel = 2'((sel + 1) % 3); inverse = ~inv;
      end
      if (poke && n == 4) start = 1'b0;
      @(negedge clk);
    end
    chk(valid_o == 1'b0, poke ? "R5 frame length under mid-frame start" : "R4 idle after last",
        int'(valid_o), 0);
    chk(distinct == k, "R7 distinct address count", distinct, k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    chk(last_o == 1'b0, "R1 last in reset", int'(last_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0 && last_o == 1'b0, "R1 idle after reset", int'({valid_o, last_o}), 0);

    // R8: unused size code starts nothing
    start = 1'b1; size_sel = 2'd3;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 4; w++) begin
      chk(valid_o == 1'b0, "R8 unused size code", int'(valid_o), 0);
      @(negedge clk);
    end

    for (int s = 0; s < 3; s++) begin
      run_frame(s, 1'b0, 1'b0);   // R3 forward sweep
      run_frame(s, 1'b1, 1'b0);   // R6 reverse sweep
    end
    run_frame(0, 1'b0, 1'b1);     // R5 start ignored mid-frame
    run_frame(2, 1'b1, 1'b1);     // R5 with reverse mode

    // R2: back-to-back restart right after a frame
    run_frame(1, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule